// File: doc/BRIEF.md
# Stereo Digital Volume with Zero-Cross Deferral

This block scales a stereo stream of 24-bit two's complement PCM samples by a per-channel attenuation chosen with an 8-bit volume code. The top code is unity gain. Each step below it takes away another 0.5 dB, and the bottom code silences the channel outright. Each channel's output polarity can be flipped on its own. All arithmetic saturates to the sample width.

When zero-cross deferral is switched on, a changed volume code is held back. It is applied first to the sample at which that channel's signal passes through zero, which avoids audible steps in the waveform. Each channel keeps its own applied code and its own record of the previous sample's sign, so the two channels move to their new gains at different moments. The volume code is a level input. Until it is applied, the latest requested value is the one waiting, so a new request replaces an older one that has not yet taken effect.

The gain is a 12-entry table of unsigned Q16 multipliers covering one 6 dB octave, followed by an arithmetic right shift by whole octaves. Each output is registered one cycle after its input strobe.

Top module: `stereo_vol_zc`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Both sample outputs keep their values in every cycle after a cycle with `in_valid` low.
- R2: A sample whose effective code is 0xFF and whose channel is not inverted appears at the output unchanged.
- R3: For an effective code c from 0x01 to 0xFE, let s = 255 - c. The output is floor(x * M[s mod 12] / 2^(16 + s/12)), with s/12 an integer division. The multiplier table is M = {65536, 61870, 58409, 55142, 52057, 49145, 46396, 43801, 41350, 39037, 36854, 34792}, which is 2^16 * 10^(-k/40) rounded.
- R4: An effective code of 0x00 gives an output of exactly 0, whatever the phase bits are.
- R5: While `zc_enable` is 0, the sample in the current cycle uses the current volume input, and that code becomes the channel's applied code.
- R6: While `zc_enable` is 1, a channel's applied code changes only at a valid sample that is a zero crossing. That sample and the samples after it use the requested code present at that moment, and earlier samples use the previously applied code. Applied codes reset to 0xFF.
- R7: Bit 0 of `phase_inv` negates the left output and bit 1 negates the right output, each independently of the other. Both reset to non-inverted.
- R8: Inverting a result equal to -2^23 gives +2^23-1.
- R9: After reset, `out_valid` is 0 and both sample outputs are 0.
- R10: A zero crossing is a valid sample that equals 0, or whose sign differs from the sign of the previous valid sample on the same channel. The stored sign resets to non-negative. Each channel detects crossings separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe for both channels |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| vol_left | input | 8 | Requested left volume code |
| vol_right | input | 8 | Requested right volume code |
| zc_enable | input | 1 | 1 defers code changes to a zero crossing |
| phase_inv | input | 2 | Bit 0 inverts left, bit 1 inverts right |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |

## Verification
Two functions can land on the same sample: the deferred code switch at a zero crossing, and the gain, mute and inversion applied to that crossing sample. The applied code changes in the same cycle that this sample is scaled. The bench provokes this with directed sequences where one channel's sign flips while its requested code differs from the applied one, and the other channel stays on one side of zero. Randomly chosen small-magnitude samples produce many more such coincidences, including crossings onto mute and crossings with inversion. Every output is compared with a bench model that tracks the applied code and the previous sign of each channel on its own.

// File: rtl/svz_pkg.sv
package svz_pkg;

  // fractional bits of the octave multipliers
  localparam int FRAC_W    = 16;
  // multiplier width: unity (1.0) needs one integer bit
  localparam int MULT_W    = FRAC_W + 1;
  // half-dB steps per 6 dB octave
  localparam int OCT_STEPS = 12;

  // 2^16 * 10^(-k/40) rounded, k = half-dB steps within an octave
  function automatic logic [MULT_W-1:0] step_mult(input logic [3:0] k);
    logic [MULT_W-1:0] m;
    case (k)
      4'd0:    m = 17'd65536;
      4'd1:    m = 17'd61870;
      4'd2:    m = 17'd58409;
      4'd3:    m = 17'd55142;
      4'd4:    m = 17'd52057;
      4'd5:    m = 17'd49145;
      4'd6:    m = 17'd46396;
      4'd7:    m = 17'd43801;
      4'd8:    m = 17'd41350;
      4'd9:    m = 17'd39037;
      4'd10:   m = 17'd36854;
      4'd11:   m = 17'd34792;
      default: m = 17'd0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/svz_zc_detect.sv
module svz_zc_detect #(
  parameter int SAMPLE_W = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic                       zc_hit
);

  logic prev_neg_q;
  logic cur_neg;
  logic is_zero;

  assign cur_neg = sample[SAMPLE_W-1];
  assign is_zero = (sample == '0);
  assign zc_hit  = in_valid && (is_zero || (cur_neg != prev_neg_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_neg_q <= 1'b0;
    end else if (in_valid) begin
      prev_neg_q <= cur_neg;
    end
  end

endmodule

// File: rtl/svz_code_track.sv
module svz_code_track #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zc_enable,
  input  logic              zc_hit,
  input  logic [CODE_W-1:0] req_code,
  output logic [CODE_W-1:0] eff_code,
  output logic [CODE_W-1:0] applied_code,
  output logic              pending
);

  logic [CODE_W-1:0] applied_q;
  logic              apply_now;

  // without deferral a request lands at once; with it, only on a crossing
  assign apply_now    = !zc_enable || zc_hit;
  assign eff_code     = apply_now ? req_code : applied_q;
  assign applied_code = applied_q;
  assign pending      = (req_code != applied_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied_q <= '1;
    end else if (apply_now) begin
      applied_q <= req_code;
    end
  end

endmodule

// File: rtl/svz_gain_path.sv
module svz_gain_path #(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic        [CODE_W-1:0]   code,
  input  logic                       invert,
  output logic signed [SAMPLE_W-1:0] out_sample
);

  import svz_pkg::*;

  localparam int PROD_W = SAMPLE_W + MULT_W;
  localparam logic [CODE_W-1:0] TOP_CODE = '1;
  localparam logic [CODE_W-1:0] OCT_DIV  = CODE_W'(OCT_STEPS);

  // negate with saturation of the most negative value
  function automatic logic signed [SAMPLE_W-1:0] neg_sat(
    input logic signed [SAMPLE_W-1:0] v
  );
    logic signed [SAMPLE_W-1:0] most_neg;
    most_neg = {1'b1, {(SAMPLE_W-1){1'b0}}};
    if (v == most_neg) return ~most_neg;
    return -v;
  endfunction

  logic [CODE_W-1:0]          steps;
  logic [CODE_W-1:0]          octave;
  logic [CODE_W-1:0]          sub_step;
  logic [MULT_W-1:0]          mult;
  logic signed [PROD_W-1:0]   prod;
  logic signed [PROD_W-1:0]   shifted;
  logic signed [SAMPLE_W-1:0] scaled;
  logic signed [SAMPLE_W-1:0] result;
  logic                       mute;

  assign steps    = TOP_CODE - code;
  assign octave   = steps / OCT_DIV;
  assign sub_step = steps % OCT_DIV;
  assign mult     = step_mult(sub_step[3:0]);
  assign prod     = PROD_W'(sample) * $signed({1'b0, mult});
  assign shifted  = prod >>> (FRAC_W + int'(octave));
  assign scaled   = shifted[SAMPLE_W-1:0];
  assign mute     = (code == '0);

  always_comb begin
    if (mute)        result = '0;
    else if (invert) result = neg_sat(scaled);
    else             result = scaled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sample <= '0;
    end else if (in_valid) begin
      out_sample <= result;
    end
  end

endmodule

// File: rtl/stereo_vol_zc.sv
module stereo_vol_zc #(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] in_left,
  input  logic signed [SAMPLE_W-1:0] in_right,
  input  logic        [CODE_W-1:0]   vol_left,
  input  logic        [CODE_W-1:0]   vol_right,
  input  logic                       zc_enable,
  input  logic        [1:0]          phase_inv,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_left,
  output logic signed [SAMPLE_W-1:0] out_right
);

  localparam int NCH = 2;

  logic [NCH-1:0][SAMPLE_W-1:0] ch_in;
  logic [NCH-1:0][SAMPLE_W-1:0] ch_out;
  logic [NCH-1:0][CODE_W-1:0]   ch_req;
  logic [NCH-1:0][CODE_W-1:0]   ch_eff;
  logic [NCH-1:0][CODE_W-1:0]   ch_app;
  logic [NCH-1:0]               ch_zc;
  logic [NCH-1:0]               ch_pend;

  // named events for the checker
  logic              zc_l, zc_r;
  logic [CODE_W-1:0] eff_l, eff_r, app_l, app_r;
  logic              pend_l, pend_r;

  assign ch_in[0]  = in_left;
  assign ch_in[1]  = in_right;
  assign ch_req[0] = vol_left;
  assign ch_req[1] = vol_right;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    svz_zc_detect #(.SAMPLE_W(SAMPLE_W)) u_zc (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .sample   (ch_in[c]),
      .zc_hit   (ch_zc[c])
    );

    svz_code_track #(.CODE_W(CODE_W)) u_code (
      .clk          (clk),
      .rst_n        (rst_n),
      .zc_enable    (zc_enable),
      .zc_hit       (ch_zc[c]),
      .req_code     (ch_req[c]),
      .eff_code     (ch_eff[c]),
      .applied_code (ch_app[c]),
      .pending      (ch_pend[c])
    );

    svz_gain_path #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_gain (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .sample     (ch_in[c]),
      .code       (ch_eff[c]),
      .invert     (phase_inv[c]),
      .out_sample (ch_out[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];
  assign zc_l   = ch_zc[0];
  assign zc_r   = ch_zc[1];
  assign eff_l  = ch_eff[0];
  assign eff_r  = ch_eff[1];
  assign app_l  = ch_app[0];
  assign app_r  = ch_app[1];
  assign pend_l = ch_pend[0];
  assign pend_r = ch_pend[1];

endmodule

// File: rtl/svz_checker.sv
module svz_checker #(
  parameter int SAMPLE_W = 24,
  parameter int CODE_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic signed [SAMPLE_W-1:0] in_left,
  input logic        [CODE_W-1:0]   vol_left,
  input logic        [CODE_W-1:0]   vol_right,
  input logic                       zc_enable,
  input logic        [1:0]          phase_inv,
  input logic                       out_valid,
  input logic signed [SAMPLE_W-1:0] out_left,
  input logic signed [SAMPLE_W-1:0] out_right,
  input logic                       zc_l,
  input logic                       zc_r,
  input logic        [CODE_W-1:0]   eff_l,
  input logic        [CODE_W-1:0]   eff_r,
  input logic        [CODE_W-1:0]   app_l,
  input logic        [CODE_W-1:0]   app_r
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r1_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_left) && $stable(out_right)));

  a_r2_unity_left: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_l == '1 && !phase_inv[0]) |=> (out_left == $past(in_left)));

  a_r4_mute_left: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_l == '0) |=> (out_left == '0));

  a_r4_mute_right: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && eff_r == '0) |=> (out_right == '0));

  a_r5_immediate_left: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_enable |=> (app_l == $past(vol_left)));

  a_r5_immediate_right: assert property (@(posedge clk) disable iff (!rst_n)
    !zc_enable |=> (app_r == $past(vol_right)));

  a_r6_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_enable && !zc_l) |=> $stable(app_l));

  a_r6_hold_right: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_enable && !zc_r) |=> $stable(app_r));

  a_r10_zc_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_l || zc_r) |-> in_valid);

endmodule

bind stereo_vol_zc svz_checker #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_left   (in_left),
  .vol_left  (vol_left),
  .vol_right (vol_right),
  .zc_enable (zc_enable),
  .phase_inv (phase_inv),
  .out_valid (out_valid),
  .out_left  (out_left),
  .out_right (out_right),
  .zc_l      (zc_l),
  .zc_r      (zc_r),
  .eff_l     (eff_l),
  .eff_r     (eff_r),
  .app_l     (app_l),
  .app_r     (app_r)
);

// File: tb/stereo_vol_zc_test.sv
`timescale 1ns/1ps
module stereo_vol_zc_test;

  localparam int SW = 24;
  localparam int CW = 8;
  localparam longint MOST_NEG = -(longint'(1) << (SW-1));
  localparam longint MOST_POS = (longint'(1) << (SW-1)) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic signed [SW-1:0] in_left = '0;
  logic signed [SW-1:0] in_right = '0;
  logic [CW-1:0]        vol_left = '1;
  logic [CW-1:0]        vol_right = '1;
  logic                 zc_enable = 1'b0;
  logic [1:0]           phase_inv = 2'b00;
  logic                 out_valid;
  logic signed [SW-1:0] out_left;
  logic signed [SW-1:0] out_right;

  int checks = 0;
  int fails  = 0;

  // bench model state per channel
  int     m_app [2];
  bit     m_neg [2];
  longint m_out [2];

  always #10 clk = ~clk;

  stereo_vol_zc uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .vol_left  (vol_left),
    .vol_right (vol_right),
    .zc_enable (zc_enable),
    .phase_inv (phase_inv),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
  );

  function automatic longint oct_gain(int k);
    case (k)
      0: return 65536;  1: return 61870;  2: return 58409;  3: return 55142;
      4: return 52057;  5: return 49145;  6: return 46396;  7: return 43801;
      8: return 41350;  9: return 39037;  10: return 36854; default: return 34792;
    endcase
  endfunction

  // expected output from the requirement formulas
  function automatic longint expect_out(longint x, int code, bit inv);
    longint v;
    int     s;
    if (code == 0) return 0;
    s = 255 - code;
    v = (x * oct_gain(s % 12)) >>> (16 + s / 12);
    if (inv) v = (v == MOST_NEG) ? MOST_POS : -v;
    return v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle at a falling edge, then check at the next falling edge
  task automatic cycle(string req, bit v, longint l, longint r,
                       int vl, int vr, bit zce, bit [1:0] ph);
    longint smp [2];
    int     req_c [2];
    bit     zc, apply;
    int     code;
    in_valid  = v;
    in_left   = SW'(l);
    in_right  = SW'(r);
    vol_left  = CW'(vl);
    vol_right = CW'(vr);
    zc_enable = zce;
    phase_inv = ph;
    smp[0] = l;  smp[1] = r;
    req_c[0] = vl; req_c[1] = vr;
    for (int c = 0; c < 2; c++) begin
      zc    = v && (smp[c] == 0 || ((smp[c] < 0) != m_neg[c]));
      apply = !zce || zc;
      code  = apply ? req_c[c] : m_app[c];
      if (apply) m_app[c] = req_c[c];
      if (v) begin
        m_neg[c] = (smp[c] < 0);
        m_out[c] = expect_out(smp[c], code, ph[c]);
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({req, " valid"}, longint'(out_valid), longint'(v));
    check({req, " left"},  longint'(out_left),  m_out[0]);
    check({req, " right"}, longint'(out_right), m_out[1]);
  endtask

  function automatic longint rnd_sample();
    int sel = $urandom_range(0, 9);
    if (sel == 0) return 0;
    if (sel == 1) return MOST_NEG;
    if (sel < 6)  return longint'($urandom_range(0, 40)) - 20;
    return longint'(signed'(SW'($urandom())));
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int vl, vr;
    bit zce;
    bit [1:0] ph;
    void'($urandom(32'h5eed_0017));
    for (int c = 0; c < 2; c++) begin
      m_app[c] = 255; m_neg[c] = 1'b0; m_out[c] = 0;
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset valid", longint'(out_valid), 0);
    check("R9 reset left",  longint'(out_left),  0);
    check("R9 reset right", longint'(out_right), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 unity
    cycle("R2 unity", 1, 1193046, -5, 255, 255, 0, 2'b00);
    // R3 single step and deep attenuation
    cycle("R3 step", 1, 4194304, -4194304, 254, 1, 0, 2'b00);
    cycle("R3 mid", 1, -1234567, 7654321, 128, 200, 0, 2'b00);
    // R1 idle cycle holds outputs
    cycle("R1 idle", 0, 99, 99, 10, 10, 0, 2'b00);
    // R4 mute overrides inversion
    cycle("R4 mute", 1, -100, 8000000, 0, 0, 0, 2'b11);
    // R8 and R7: invert only left at the most negative value
    cycle("R8 sat invert", 1, MOST_NEG, 100, 255, 255, 0, 2'b01);
    cycle("R7 right only", 1, 300, -300, 255, 255, 0, 2'b10);
    // R5 immediate change on a same-sign sample
    cycle("R5 immediate", 1, 5000, 5000, 230, 231, 0, 2'b00);
    // R6 and R10: deferral, left crosses while right stays positive
    cycle("R6 setup", 1, 2000, 2000, 255, 255, 0, 2'b00);
    cycle("R6 held", 1, 2100, 2100, 128, 128, 1, 2'b00);
    cycle("R6 replaced", 1, 2200, 2200, 100, 90, 1, 2'b00);
    cycle("R10 left crosses", 1, -3000, 2300, 100, 90, 1, 2'b00);
    cycle("R10 right zero", 1, -3100, 0, 100, 90, 1, 2'b00);
    cycle("R6 crossing onto mute", 1, 50, -40, 0, 0, 1, 2'b11);

    // constrained random mix
    vl = 255; vr = 255; zce = 1'b0; ph = 2'b00;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) vl = $urandom_range(0, 255);
      if ($urandom_range(0, 9) == 0) vr = $urandom_range(0, 255);
      if ($urandom_range(0, 49) == 0) zce = ~zce;
      if ($urandom_range(0, 29) == 0) ph = 2'($urandom());
      cycle(zce ? "R6 R10 random" : "R3 R5 random",
            $urandom_range(0, 4) != 0, rnd_sample(), rnd_sample(),
            vl, vr, zce, ph);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule